// File: doc/BRIEF.md
# Windowed Memory Bank Mapper

This block sits between an 8-bit processor with a 64 KB address space and three 64 KB physical memories: a ROM bank, a static RAM bank and a dynamic RAM bank. The processor space is cut into sixteen 4 KB windows. Each window can be pointed at the page with the same number in any one of the three banks, independently of the others. Every processor address is turned into an 18-bit physical address: the bank number in the top two bits and the in-bank address below it.

Software remaps a window with one I/O write. The data byte carries a one-hot bank code. A companion byte, presented with the write, names the window in its upper four bits. A zero code is a no-op. Any other code that is not one-hot is rejected and produces a one-cycle error pulse. The block also marks accesses that land in regions of a bank that hold no memory. It blocks writes aimed at the ROM bank and raises a pulse when one is attempted.

Top module: `win_bank_mapper`

## Requirements
- R1: For a memory access, `phys_addr[17:16]` is the window's bank (0 = ROM, 1 = static RAM, 2 = dynamic RAM), `phys_addr[15:12]` is the window's page and `phys_addr[11:0]` equals `mem_addr[11:0]`; the window is `mem_addr[15:12]`.
- R2: After reset, every window maps to bank 0, page 0.
- R3: An I/O write to addresses 0x00–0x07 with data 0x01, 0x02 or 0x04 maps window `io_sel[7:4]` to the same-numbered page of bank 0, 1 or 2 respectively. The new mapping is visible from the cycle after the write strobe. Other windows keep their mapping.
- R4: An I/O write of data 0x00 to the control port changes no mapping and raises no error.
- R5: An I/O write to the control port of any nonzero data other than 0x01, 0x02 or 0x04 changes no mapping and drives `code_err` high for exactly the following cycle.
- R6: I/O writes to addresses outside 0x00–0x07 change no mapping and raise no error.
- R7: While `mem_valid` is high, `unpop` is high when the in-bank address (`phys_addr[15:0]`) is above 0x1FFF in bank 0, or outside 0x2000–0x2FFF in bank 1. It is never high for bank 2, and it is low whenever `mem_valid` is low.
- R8: A write access (`mem_valid` and `mem_we`) through a window mapped to bank 0 keeps `phys_we` low and drives `wp_err` high in the same cycle. A write to bank 1 or 2 drives `phys_we` high and `wp_err` low.
- R9: `io_rdata` is always 0x00.
- R10: Bits `io_sel[3:0]` do not affect which window is remapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 8 | I/O address |
| io_wdata | input | 8 | I/O write data, the bank code |
| io_sel | input | 8 | Companion byte; upper nibble names the window |
| io_rdata | output | 8 | Read data of the control port, always zero |
| mem_addr | input | 16 | Processor memory address |
| mem_valid | input | 1 | Memory access in progress |
| mem_we | input | 1 | Access is a write |
| phys_addr | output | 18 | Translated physical address {bank, page, offset} |
| phys_we | output | 1 | Write enable passed to the memories |
| unpop | output | 1 | Access targets an unpopulated region |
| wp_err | output | 1 | Write to the ROM bank was blocked |
| code_err | output | 1 | One-cycle pulse after a rejected bank code |

## Verification
Translation is exercised by sweeping reads over all sixteen windows right after reset. It is then exercised again after remapping windows to each bank: one window to a bank page that holds memory and another to a page that does not, so that a wrong page field and a wrong populated range show up as different miscompares. The bank codes cover the three one-hot values, zero, multi-bit values and a high single bit. These tell a correct one-hot decode apart from a decode that looks only at the low bits. Port writes at the first, last and first-outside addresses of the decoded range, and companion bytes with a nonzero low nibble, check the address and window decode. An access issued in the cycle right after a remap shows when the new mapping takes effect.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  localparam int BANK_W = 2;

  typedef enum logic [BANK_W-1:0] {
    BANK_ROM  = 2'd0,
    BANK_SRAM = 2'd1,
    BANK_DRAM = 2'd2
  } bank_e;
endpackage

// File: rtl/wbm_rst_sync.sv
module wbm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/wbm_io_decode.sv
module wbm_io_decode #(
  parameter int          IO_AW     = 8,
  parameter logic [7:0]  PORT_BASE = 8'h00,
  parameter int          SPAN_W    = 3,
  parameter int          N_BANKS   = 3,
  parameter int          WIN_W     = 4,
  parameter int          BANK_W    = wbm_pkg::BANK_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              io_wr,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [7:0]        io_wdata,
  input  logic [7:0]        io_sel,
  output logic              upd_en,
  output logic [WIN_W-1:0]  upd_win,
  output logic [BANK_W-1:0] upd_bank,
  output logic              code_err
);
  localparam int TAG_W = IO_AW - SPAN_W;

  logic               port_hit;
  logic [N_BANKS-1:0] code_match;
  logic               code_ok;
  logic               code_zero;
  logic               err_d;
  logic               err_q;

  assign port_hit = io_wr && (io_addr[IO_AW-1:SPAN_W] == PORT_BASE[IO_AW-1:SPAN_W]);

  for (genvar b = 0; b < N_BANKS; b++) begin : g_code
    assign code_match[b] = (io_wdata == 8'(1 << b));
  end

  assign code_ok   = |code_match;
  assign code_zero = (io_wdata == 8'h00);

  always_comb begin
    upd_bank = '0;
    for (int b = 0; b < N_BANKS; b++) begin
      if (code_match[b]) upd_bank = BANK_W'(b);
    end
  end

  assign upd_en  = port_hit && code_ok;
  assign upd_win = io_sel[7 -: WIN_W];

  always_comb begin
    err_d = port_hit && !code_ok && !code_zero;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign code_err = err_q;

  logic unused_tag;
  assign unused_tag = ^{TAG_W{1'b0}};
endmodule

// File: rtl/wbm_map_table.sv
module wbm_map_table #(
  parameter int WIN_W  = 4,
  parameter int BANK_W = wbm_pkg::BANK_W
) (
  input  logic                                   clk,
  input  logic                                   rst_ni,
  input  logic                                   upd_en,
  input  logic [WIN_W-1:0]                       upd_win,
  input  logic [BANK_W-1:0]                      upd_bank,
  output logic [(1<<WIN_W)*(BANK_W+WIN_W)-1:0]   map_flat
);
  localparam int N_WIN = 1 << WIN_W;
  localparam int ENT_W = BANK_W + WIN_W;

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    logic             ld;
    logic [ENT_W-1:0] ent_d;
    logic [ENT_W-1:0] ent_q;

    assign ld = upd_en && (upd_win == WIN_W'(w));

    always_comb begin
      ent_d = ent_q;
      if (ld) ent_d = {upd_bank, WIN_W'(w)};
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) ent_q <= '0;
      else         ent_q <= ent_d;
    end

    assign map_flat[w*ENT_W +: ENT_W] = ent_q;
  end
endmodule

// File: rtl/wbm_xlate.sv
module wbm_xlate #(
  parameter int WIN_W   = 4,
  parameter int OFF_W   = 12,
  parameter int N_BANKS = 3,
  parameter int BANK_W  = wbm_pkg::BANK_W,
  parameter int RO_BANK = 0,
  parameter logic [N_BANKS*(WIN_W+OFF_W)-1:0] POP_LO = '0,
  parameter logic [N_BANKS*(WIN_W+OFF_W)-1:0] POP_HI = '1
) (
  input  logic [WIN_W+OFF_W-1:0]               mem_addr,
  input  logic                                 mem_valid,
  input  logic                                 mem_we,
  input  logic [(1<<WIN_W)*(BANK_W+WIN_W)-1:0] map_flat,
  output logic [BANK_W+WIN_W+OFF_W-1:0]        phys_addr,
  output logic                                 phys_we,
  output logic                                 unpop,
  output logic                                 wp_err
);
  localparam int CPU_AW = WIN_W + OFF_W;
  localparam int ENT_W  = BANK_W + WIN_W;

  logic [WIN_W-1:0]   win;
  logic [ENT_W-1:0]   ent;
  logic [BANK_W-1:0]  bank;
  logic [CPU_AW-1:0]  inb;
  logic [N_BANKS-1:0] pop_vec;
  logic               populated;
  logic               ro_hit;

  assign win  = mem_addr[CPU_AW-1:OFF_W];
  assign ent  = map_flat[win*ENT_W +: ENT_W];
  assign bank = ent[ENT_W-1:WIN_W];
  assign inb  = {ent[WIN_W-1:0], mem_addr[OFF_W-1:0]};

  for (genvar b = 0; b < N_BANKS; b++) begin : g_pop
    assign pop_vec[b] = (inb >= POP_LO[b*CPU_AW +: CPU_AW]) &&
                        (inb <= POP_HI[b*CPU_AW +: CPU_AW]);
  end

  always_comb begin
    populated = 1'b0;
    for (int b = 0; b < N_BANKS; b++) begin
      if (bank == BANK_W'(b)) populated = pop_vec[b];
    end
  end

  assign ro_hit    = (bank == BANK_W'(RO_BANK));
  assign phys_addr = {bank, inb};
  assign unpop     = mem_valid && !populated;
  assign wp_err    = mem_valid && mem_we && ro_hit;
  assign phys_we   = mem_valid && mem_we && !ro_hit;
endmodule

// File: rtl/win_bank_mapper.sv
module win_bank_mapper #(
  parameter int         IO_AW     = 8,
  parameter logic [7:0] PORT_BASE = 8'h00,
  parameter int         SPAN_W    = 3,
  parameter int         WIN_W     = 4,
  parameter int         OFF_W     = 12,
  parameter int         N_BANKS   = 3,
  parameter int         RO_BANK   = 0,
  parameter logic [N_BANKS*(WIN_W+OFF_W)-1:0] POP_LO = {16'h0000, 16'h2000, 16'h0000},
  parameter logic [N_BANKS*(WIN_W+OFF_W)-1:0] POP_HI = {16'hFFFF, 16'h2FFF, 16'h1FFF}
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      io_wr,
  input  logic [IO_AW-1:0]                          io_addr,
  input  logic [7:0]                                io_wdata,
  input  logic [7:0]                                io_sel,
  output logic [7:0]                                io_rdata,
  input  logic [WIN_W+OFF_W-1:0]                    mem_addr,
  input  logic                                      mem_valid,
  input  logic                                      mem_we,
  output logic [wbm_pkg::BANK_W+WIN_W+OFF_W-1:0]    phys_addr,
  output logic                                      phys_we,
  output logic                                      unpop,
  output logic                                      wp_err,
  output logic                                      code_err
);
  localparam int BANK_W = wbm_pkg::BANK_W;
  localparam int N_WIN  = 1 << WIN_W;
  localparam int ENT_W  = BANK_W + WIN_W;

  logic                     rst_sync_n;
  logic                     upd_en;
  logic [WIN_W-1:0]         upd_win;
  logic [BANK_W-1:0]        upd_bank;
  logic [N_WIN*ENT_W-1:0]   map_flat;

  wbm_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  wbm_io_decode #(
    .IO_AW(IO_AW), .PORT_BASE(PORT_BASE), .SPAN_W(SPAN_W),
    .N_BANKS(N_BANKS), .WIN_W(WIN_W), .BANK_W(BANK_W)
  ) u_dec (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .io_wr   (io_wr),
    .io_addr (io_addr),
    .io_wdata(io_wdata),
    .io_sel  (io_sel),
    .upd_en  (upd_en),
    .upd_win (upd_win),
    .upd_bank(upd_bank),
    .code_err(code_err)
  );

  wbm_map_table #(.WIN_W(WIN_W), .BANK_W(BANK_W)) u_tbl (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .upd_en  (upd_en),
    .upd_win (upd_win),
    .upd_bank(upd_bank),
    .map_flat(map_flat)
  );

  wbm_xlate #(
    .WIN_W(WIN_W), .OFF_W(OFF_W), .N_BANKS(N_BANKS), .BANK_W(BANK_W),
    .RO_BANK(RO_BANK), .POP_LO(POP_LO), .POP_HI(POP_HI)
  ) u_xl (
    .mem_addr (mem_addr),
    .mem_valid(mem_valid),
    .mem_we   (mem_we),
    .map_flat (map_flat),
    .phys_addr(phys_addr),
    .phys_we  (phys_we),
    .unpop    (unpop),
    .wp_err   (wp_err)
  );

  assign io_rdata = 8'h00;
endmodule

// File: rtl/wbm_chk.sv
module wbm_chk #(
  parameter int IO_AW  = 8,
  parameter int SPAN_W = 3,
  parameter int NF_W   = 96,
  parameter int PA_W   = 18,
  parameter int CPU_AW = 16
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              io_wr,
  input logic [IO_AW-1:0]  io_addr,
  input logic [7:0]        io_wdata,
  input logic [NF_W-1:0]   map_flat,
  input logic [CPU_AW-1:0] mem_addr,
  input logic              mem_valid,
  input logic [PA_W-1:0]   phys_addr,
  input logic              phys_we,
  input logic              unpop,
  input logic              wp_err,
  input logic              code_err
);
  logic hit;
  logic good;
  assign hit  = io_wr && (io_addr[IO_AW-1:SPAN_W] == '0);
  assign good = (io_wdata == 8'h01) || (io_wdata == 8'h02) || (io_wdata == 8'h04);

  // R1
  offset_passthru_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_valid |-> (phys_addr[11:0] == mem_addr[11:0]));

  // R5
  bad_code_flag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (hit && !good && io_wdata != 8'h00) |=> code_err);

  // R5
  bad_code_keeps_map_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (hit && !good) |=> $stable(map_flat));

  // R4
  good_code_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (hit && (good || io_wdata == 8'h00)) |=> !code_err);

  // R6
  no_write_no_change_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !hit |=> ($stable(map_flat) && !code_err));

  // R7
  dram_always_pop_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_valid && phys_addr[PA_W-1 -: 2] == 2'd2) |-> !unpop);

  // R8
  wp_blocks_we_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    wp_err |-> !phys_we);
endmodule

bind win_bank_mapper wbm_chk #(
  .IO_AW(IO_AW), .SPAN_W(SPAN_W), .NF_W(N_WIN*ENT_W),
  .PA_W(BANK_W+WIN_W+OFF_W), .CPU_AW(WIN_W+OFF_W)
) u_chk (
  .clk      (clk),
  .rst_ni   (rst_sync_n),
  .io_wr    (io_wr),
  .io_addr  (io_addr),
  .io_wdata (io_wdata),
  .map_flat (map_flat),
  .mem_addr (mem_addr),
  .mem_valid(mem_valid),
  .phys_addr(phys_addr),
  .phys_we  (phys_we),
  .unpop    (unpop),
  .wp_err   (wp_err),
  .code_err (code_err)
);

// File: tb/win_bank_mapper_tb.sv
module win_bank_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_wr;
  logic [7:0]  io_addr, io_wdata, io_sel, io_rdata;
  logic [15:0] mem_addr;
  logic        mem_valid, mem_we;
  logic [17:0] phys_addr;
  logic        phys_we, unpop, wp_err, code_err;

  always #4 clk = ~clk;

  win_bank_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_sel(io_sel), .io_rdata(io_rdata),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_we(mem_we),
    .phys_addr(phys_addr), .phys_we(phys_we), .unpop(unpop),
    .wp_err(wp_err), .code_err(code_err)
  );

  int m_bank[16];
  int m_page[16];
  bit m_err;
  int n_vec = 0;
  int n_bad = 0;

  task automatic model_reset();
    for (int w = 0; w < 16; w++) begin
      m_bank[w] = 0;
      m_page[w] = 0;
    end
    m_err = 1'b0;
  endtask

  task automatic cmp(string tag, string what, int act, int exp);
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit populated(int b, int inb);
    if (b == 0) return inb <= 'h1FFF;
    if (b == 1) return (inb >= 'h2000) && (inb <= 'h2FFF);
    return 1'b1;
  endfunction

  task automatic apply(string tag, bit wr, logic [7:0] ia, logic [7:0] d,
                       logic [7:0] s, int ma, bit mv, bit mw);
    int w, b, inb;
    @(negedge clk);
    io_wr = wr; io_addr = ia; io_wdata = d; io_sel = s;
    mem_addr = 16'(ma); mem_valid = mv; mem_we = mw;
    #1;
    w   = (ma >> 12) & 15;
    b   = m_bank[w];
    inb = m_page[w] * 4096 + (ma & 'hFFF);
    n_vec++;
    cmp(tag, "phys_addr", int'(phys_addr), b * 65536 + inb);
    cmp(tag, "unpop",     int'(unpop),     int'(mv && !populated(b, inb)));
    cmp(tag, "wp_err",    int'(wp_err),    int'(mv && mw && b == 0));
    cmp(tag, "phys_we",   int'(phys_we),   int'(mv && mw && b != 0));
    cmp(tag, "code_err",  int'(code_err),  int'(m_err));
    cmp("R9", "io_rdata", int'(io_rdata),  0);
    m_err = 1'b0;
    if (wr && ia[7:3] == 5'd0) begin
      case (d)
        8'h01, 8'h02, 8'h04: begin
          w = int'(s[7:4]);
          m_bank[w] = (d == 8'h01) ? 0 : (d == 8'h02) ? 1 : 2;
          m_page[w] = w;
        end
        8'h00: ;
        default: m_err = 1'b1;
      endcase
    end
  endtask

  task automatic idle(string tag, int ma);
    apply(tag, 1'b0, 8'h00, 8'h00, 8'h00, ma, 1'b1, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    repeat (2) idle("R2", 16'h5123);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle("R2", 16'h0ABC);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired, all requirements: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; io_wr = 0; io_addr = 0; io_wdata = 0; io_sel = 0;
    mem_addr = 0; mem_valid = 0; mem_we = 0;
    model_reset();
    repeat (3) @(posedge clk);
    do_reset();

    // R2: reset mapping of every window, reads and a ROM write
    for (int w = 0; w < 16; w++) idle("R2", w * 4096 + 'h345);
    apply("R8", 0, 0, 0, 0, 'h7010, 1, 1);

    // R3: one-hot codes, access issued the cycle right after the write
    apply("R3", 1, 8'h00, 8'h02, 8'h20, 'h2FFF, 1, 0);
    idle("R3", 'h2FFF);
    apply("R3", 1, 8'h07, 8'h04, 8'h50, 'h5000, 1, 1);
    apply("R3", 0, 0, 0, 0, 'h5ABC, 1, 1);
    apply("R3", 1, 8'h03, 8'h01, 8'h10, 'h1800, 1, 0);
    idle("R3", 'h1800);
    apply("R3", 1, 8'h04, 8'h01, 8'h90, 'h9000, 1, 0);
    idle("R7", 'h9FFF);
    apply("R8", 0, 0, 0, 0, 'h9004, 1, 1);
    apply("R3", 1, 8'h01, 8'h02, 8'hC0, 'hC000, 1, 0);
    idle("R7", 'hC123);
    apply("R8", 0, 0, 0, 0, 'hC123, 1, 1);
    apply("R3", 1, 8'h00, 8'h04, 8'hF0, 'hF000, 1, 0);
    idle("R3", 'hFFFF);

    // R10: low nibble of companion byte ignored
    apply("R10", 1, 8'h02, 8'h04, 8'h3F, 'h3000, 1, 0);
    idle("R10", 'h3555);
    idle("R10", 'hF555);

    // R4: zero code
    apply("R4", 1, 8'h00, 8'h00, 8'h30, 0, 0, 0);
    idle("R4", 'h3555);

    // R5: invalid codes
    apply("R5", 1, 8'h05, 8'h03, 8'h30, 0, 0, 0);
    idle("R5", 'h3555);
    idle("R5", 'h3555);
    apply("R5", 1, 8'h00, 8'h08, 8'h20, 0, 0, 0);
    apply("R5", 1, 8'h00, 8'hFF, 8'h20, 'h2100, 1, 0);
    apply("R5", 1, 8'h06, 8'h80, 8'h50, 'h2100, 1, 0);
    idle("R5", 'h5100);
    idle("R5", 'h5100);

    // R6: outside the port range
    apply("R6", 1, 8'h08, 8'h04, 8'h00, 0, 0, 0);
    idle("R6", 'h0100);
    apply("R6", 1, 8'hF0, 8'h03, 8'h10, 0, 0, 0);
    idle("R6", 'h1100);

    // R7: mem_valid low masks unpop
    apply("R7", 0, 0, 0, 0, 'h9000, 0, 1);

    // R2: reset in mid-run restores the map
    do_reset();
    for (int w = 0; w < 16; w++) idle("R2", w * 4096 + 'hFFF);

    // R1: walk all windows through bank 2 then read each
    for (int w = 0; w < 16; w++) apply("R1", 1, 8'h00, 8'h04, 8'(w << 4), 0, 0, 0);
    for (int w = 0; w < 16; w++) idle("R1", w * 4096 + w * 17);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule